// File: doc/BRIEF.md
# Waveform Timer Channel

This block is a single timer/counter channel that generates waveforms. A counter advances on edges of a selected clock level. It runs in one of four counting schemes and can halt or lock itself when it reaches the RC limit. It drives two output pins, A and B. Each pin has its own action (none, set, clear or toggle) for each of four event sources: the software trigger, an external event, RC compare, and a per-pin compare (RA for pin A, RB for pin B).

Software programs a 30-bit mode word and the RA, RB and RC values through one write port. A write-protect input locks the mode word. Enable, disable and trigger commands are single-cycle pulses. The clock level is either `tick_in` or one of three auxiliary levels. It can be gated by another auxiliary level and can count on falling edges. The external event comes from pin B or from an auxiliary level. It can also restart the counter.

Top module: `wtc_chan`

## Requirements
- R1: After reset the counter reads 0, both pins and all hit flags are 0, and `pin_b_oe` is 0. The mode word and RA/RB/RC reset to 0, and the counter clock resets to the disabled state.
- R2: While `wprot` is 1, a write to address 0 (the mode word) is ignored. Writes to RA (address 1), RB (address 2) and RC (address 3) are always accepted.
- R3: A trigger (the `cmd_trig` pulse, or an external event when bit 11 is set) clears the counter. It starts the counter clock only if the clock is not disabled. `cmd_dis` halts and disables the clock. `cmd_en` only clears the disabled state. With the clock halted, the counter holds its value.
- R4: Wave select (bits 13:12) = 0: the counter adds one on each active clock edge and wraps from all-ones to 0.
- R5: Clock source (bits 1:0) selects the level: 0 = `tick_in`, 1/2/3 = `aux_in[0]`/`[1]`/`[2]`. Bit 2 = 0 counts on rising edges and bit 2 = 1 on falling edges. Levels that are not selected have no effect.
- R6: Gate select (bits 4:3) = 1/2/3 ANDs the clock level with `aux_in[0]`/`[1]`/`[2]` before edge detection. A value of 0 applies no gating.
- R7: Wave select = 2: once the counter equals RC, the next active edge loads 0.
- R8: Wave select = 1 or 3 counts up and down. The count reverses at all-ones (for 1) or at RC (for 3), and climbs again after reaching 0.
- R9: Bit 5 set: reaching RC halts the clock, and any trigger restarts it. Bit 6 set: reaching RC halts and disables the clock, and a trigger restarts it only after a `cmd_en`.
- R10: Pin action codes are 0 = none, 1 = set, 2 = clear, 3 = toggle. Fields: pin A per-pin compare 15:14, RC 17:16, external 19:18, software 21:20. Pin B per-pin compare 23:22, RC 25:24, external 27:26, software 29:28. Compare events occur only on counting steps, when the new count equals the register.
- R11: When several events reach one pin in the same cycle, the one with the highest priority that has a non-none action wins. Priority from highest to lowest: software, external, RC, per-pin compare.
- R12: The external-event source (bits 10:9) is 0 = `pin_b_in` or 1/2/3 = `aux_in[0..2]`. The edge (bits 8:7) is 0 = none, 1 = rising, 2 = falling, 3 = both. With bit 11 clear, the event drives only pin actions.
- R13: With external-event source 0, `pin_b_oe` is 0 and pin B holds its value. Otherwise `pin_b_oe` is 1.
- R14: `hit_ra`, `hit_rb` and `hit_rc` pulse for one cycle, together with the count that matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Prescaled clock level, source 0 |
| aux_in | input | 3 | Auxiliary levels for clock, gating and events |
| pin_b_in | input | 1 | Pin B input level when used as event source |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 mode, 1 RA, 2 RB, 3 RC |
| cfg_wdata | input | 30 | Write data |
| wprot | input | 1 | Locks the mode word |
| cmd_en | input | 1 | Clear disabled state |
| cmd_dis | input | 1 | Halt and disable clock |
| cmd_trig | input | 1 | Software trigger |
| cnt_val | output | CNT_W | Counter value |
| pin_a | output | 1 | Waveform pin A |
| pin_b | output | 1 | Waveform pin B |
| pin_b_oe | output | 1 | Pin B drives output |
| hit_ra | output | 1 | RA compare pulse |
| hit_rb | output | 1 | RB compare pulse |
| hit_rc | output | 1 | RC compare pulse |

## Verification
The bench builds the channel with a 4-bit counter (`CNT_W` = 4). This puts the all-ones wrap of wave select 0 and the all-ones reversal of wave select 1 within sixteen clock steps. RC values of 3 to 6 keep the RC-bounded schemes, the halt and lock paths, and the compare-driven pin actions short. A vector table covers the pin action codes and the same-cycle priority, and directed tests cover the remaining corners.

// File: rtl/wtc_pkg.sv
`timescale 1ns/100ps
package wtc_pkg;

   localparam int AUX_N = 3;

   typedef enum logic [1:0] {
      ACT_NONE = 2'd0,
      ACT_SET  = 2'd1,
      ACT_CLR  = 2'd2,
      ACT_TGL  = 2'd3
   } act_e;

   // mode word, 30 bits, MSB first
   typedef struct packed {
      logic [1:0] b_sw;
      logic [1:0] b_ext;
      logic [1:0] b_rc;
      logic [1:0] b_cmp;
      logic [1:0] a_sw;
      logic [1:0] a_ext;
      logic [1:0] a_rc;
      logic [1:0] a_cmp;
      logic [1:0] wave_sel;
      logic       ev_trig;
      logic [1:0] ev_src;
      logic [1:0] ev_edge;
      logic       rc_dis;
      logic       rc_stop;
      logic [1:0] gate_sel;
      logic       clk_inv;
      logic [1:0] clk_src;
   } mode_t;

   localparam int MODE_W = $bits(mode_t);

   localparam logic [1:0] ADDR_MODE = 2'd0;
   localparam logic [1:0] ADDR_RA   = 2'd1;
   localparam logic [1:0] ADDR_RB   = 2'd2;
   localparam logic [1:0] ADDR_RC   = 2'd3;

   // hit/act index 3 = software, 2 = external, 1 = RC, 0 = per-pin compare
   function automatic logic resolve_pin(input logic cur, input logic [3:0] hit,
                                        input logic [7:0] act);
      logic res;
      logic done;
      act_e code;
      res  = cur;
      done = 1'b0;
      for (int i = 3; i >= 0; i--) begin
         code = act_e'(act[2*i +: 2]);
         if (!done && hit[i] && code != ACT_NONE) begin
            done = 1'b1;
            unique case (code)
               ACT_SET: res = 1'b1;
               ACT_CLR: res = 1'b0;
               ACT_TGL: res = ~cur;
               default: res = cur;
            endcase
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/wtc_edge.sv
`timescale 1ns/100ps
module wtc_edge (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl,
   input  logic [1:0] sel,
   output logic       pulse
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   always_comb begin
      unique case (sel)
         2'd1:    pulse = lvl & ~prev_q;
         2'd2:    pulse = ~lvl & prev_q;
         2'd3:    pulse = lvl ^ prev_q;
         default: pulse = 1'b0;
      endcase
   end
endmodule

// File: rtl/wtc_counter.sv
`timescale 1ns/100ps
module wtc_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clk_edge,
   input  logic             trig,
   input  logic             cmd_en,
   input  logic             cmd_dis,
   input  logic [1:0]       wave_sel,
   input  logic             rc_stop,
   input  logic             rc_dis,
   input  logic [CNT_W-1:0] ra,
   input  logic [CNT_W-1:0] rb,
   input  logic [CNT_W-1:0] rc,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ev_ra,
   output logic             ev_rb,
   output logic             ev_rc,
   output logic             run_q,
   output logic             dis_q
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] MAXV = '1;

   logic             step;
   logic             dir_q;
   logic             dir_nxt;
   logic [CNT_W-1:0] nxt;
   logic [CNT_W-1:0] top;

   assign step = run_q & clk_edge & ~trig;

   always_comb begin
      dir_nxt = dir_q;
      nxt     = cnt_q + ONE;
      top     = wave_sel[1] ? rc : MAXV;
      if (!wave_sel[0]) begin
         dir_nxt = 1'b0;
         if (wave_sel[1] && cnt_q == rc) nxt = '0;
      end else if (!dir_q) begin
         if (cnt_q == top) begin
            dir_nxt = 1'b1;
            nxt     = cnt_q - ONE;
         end
      end else begin
         if (cnt_q == '0) dir_nxt = 1'b0;
         else             nxt     = cnt_q - ONE;
      end
   end

   assign ev_ra = step && (nxt == ra);
   assign ev_rb = step && (nxt == rb);
   assign ev_rc = step && (nxt == rc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= 1'b0;
      end else if (trig) begin
         cnt_q <= '0;
         dir_q <= 1'b0;
      end else if (step) begin
         cnt_q <= nxt;
         dir_q <= dir_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         dis_q <= 1'b1;
      end else if (cmd_dis) begin
         run_q <= 1'b0;
         dis_q <= 1'b1;
      end else begin
         if (cmd_en) dis_q <= 1'b0;
         if (trig) begin
            run_q <= ~dis_q;
         end else if (ev_rc && (rc_stop || rc_dis)) begin
            run_q <= 1'b0;
            if (rc_dis) dis_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/wtc_pin.sv
`timescale 1ns/100ps
module wtc_pin
   import wtc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd_en,
   input  logic [3:0] hit,
   input  logic [7:0] act,
   output logic       pin_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pin_q <= 1'b0;
      else if (upd_en) pin_q <= resolve_pin(pin_q, hit, act);
   end
endmodule

// File: rtl/wtc_chan.sv
`timescale 1ns/100ps
module wtc_chan
   import wtc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_in,
   input  logic [AUX_N-1:0]  aux_in,
   input  logic              pin_b_in,
   input  logic              cfg_wr,
   input  logic [1:0]        cfg_addr,
   input  logic [MODE_W-1:0] cfg_wdata,
   input  logic              wprot,
   input  logic              cmd_en,
   input  logic              cmd_dis,
   input  logic              cmd_trig,
   output logic [CNT_W-1:0]  cnt_val,
   output logic              pin_a,
   output logic              pin_b,
   output logic              pin_b_oe,
   output logic              hit_ra,
   output logic              hit_rb,
   output logic              hit_rc
);
   localparam int PIN_N = 2;

   if (CNT_W < 2 || CNT_W > MODE_W) begin : g_bad_width
      $error("wtc_chan: CNT_W out of range");
   end

   mode_t            mode_q;
   logic [CNT_W-1:0] ra_q, rb_q, rc_q;
   logic [AUX_N:0]   clk_pool, gate_pool, ev_pool;
   logic             gated_lvl, clk_edge, ext_ev, trig_any;
   logic             ev_ra, ev_rb, ev_rc, run_q, dis_q;
   logic [PIN_N-1:0][3:0] pin_hit;
   logic [PIN_N-1:0][7:0] pin_act;
   logic [PIN_N-1:0]      pin_upd;
   logic [PIN_N-1:0]      pin_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         ra_q   <= '0;
         rb_q   <= '0;
         rc_q   <= '0;
      end else if (cfg_wr) begin
         unique case (cfg_addr)
            ADDR_MODE: if (!wprot) mode_q <= mode_t'(cfg_wdata);
            ADDR_RA:   ra_q <= cfg_wdata[CNT_W-1:0];
            ADDR_RB:   rb_q <= cfg_wdata[CNT_W-1:0];
            default:   rc_q <= cfg_wdata[CNT_W-1:0];
         endcase
      end
   end

   assign clk_pool  = {aux_in, tick_in};
   assign gate_pool = {aux_in, 1'b1};
   assign ev_pool   = {aux_in, pin_b_in};
   assign gated_lvl = clk_pool[mode_q.clk_src] & gate_pool[mode_q.gate_sel];

   wtc_edge u_clk_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (gated_lvl),
      .sel   (mode_q.clk_inv ? 2'd2 : 2'd1),
      .pulse (clk_edge)
   );

   wtc_edge u_ext_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (ev_pool[mode_q.ev_src]),
      .sel   (mode_q.ev_edge),
      .pulse (ext_ev)
   );

   assign trig_any = cmd_trig | (ext_ev & mode_q.ev_trig);

   wtc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_edge (clk_edge),
      .trig     (trig_any),
      .cmd_en   (cmd_en),
      .cmd_dis  (cmd_dis),
      .wave_sel (mode_q.wave_sel),
      .rc_stop  (mode_q.rc_stop),
      .rc_dis   (mode_q.rc_dis),
      .ra       (ra_q),
      .rb       (rb_q),
      .rc       (rc_q),
      .cnt_q    (cnt_val),
      .ev_ra    (ev_ra),
      .ev_rb    (ev_rb),
      .ev_rc    (ev_rc),
      .run_q    (run_q),
      .dis_q    (dis_q)
   );

   assign pin_hit[0] = {cmd_trig, ext_ev, ev_rc, ev_ra};
   assign pin_hit[1] = {cmd_trig, ext_ev, ev_rc, ev_rb};
   assign pin_act[0] = {mode_q.a_sw, mode_q.a_ext, mode_q.a_rc, mode_q.a_cmp};
   assign pin_act[1] = {mode_q.b_sw, mode_q.b_ext, mode_q.b_rc, mode_q.b_cmp};
   assign pin_b_oe   = (mode_q.ev_src != 2'd0);
   assign pin_upd    = {pin_b_oe, 1'b1};

   for (genvar gi = 0; gi < PIN_N; gi++) begin : g_pin
      wtc_pin u_pin (
         .clk    (clk),
         .rst_n  (rst_n),
         .upd_en (pin_upd[gi]),
         .hit    (pin_hit[gi]),
         .act    (pin_act[gi]),
         .pin_q  (pin_q[gi])
      );
   end

   assign pin_a = pin_q[0];
   assign pin_b = pin_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit_ra <= 1'b0;
         hit_rb <= 1'b0;
         hit_rc <= 1'b0;
      end else begin
         hit_ra <= ev_ra;
         hit_rb <= ev_rb;
         hit_rc <= ev_rc;
      end
   end
endmodule

// File: rtl/wtc_chk.sv
`timescale 1ns/100ps
module wtc_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic [1:0]       cfg_addr,
   input logic             wprot,
   input logic             cmd_en,
   input logic             trig_any,
   input logic [29:0]      mode_q,
   input logic             run_q,
   input logic             dis_q,
   input logic [CNT_W-1:0] cnt_val,
   input logic [CNT_W-1:0] rc_q,
   input logic             hit_rc,
   input logic             pin_b,
   input logic             pin_b_oe
);
   AST_WP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (wprot && cfg_wr && cfg_addr == 2'd0) |=> $stable(mode_q)); // R2

   AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      trig_any |=> (cnt_val == '0)); // R3

   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !trig_any) |=> $stable(cnt_val)); // R3

   AST_LOCK_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_q && !cmd_en) |=> !run_q); // R9

   AST_RC_HIT_VAL: assert property (@(posedge clk) disable iff (!rst_n)
      hit_rc |-> (cnt_val == $past(rc_q))); // R14

   AST_PINB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_b_oe |=> $stable(pin_b)); // R13
endmodule

bind wtc_chan wtc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_wr   (cfg_wr),
   .cfg_addr (cfg_addr),
   .wprot    (wprot),
   .cmd_en   (cmd_en),
   .trig_any (trig_any),
   .mode_q   (mode_q),
   .run_q    (run_q),
   .dis_q    (dis_q),
   .cnt_val  (cnt_val),
   .rc_q     (rc_q),
   .hit_rc   (hit_rc),
   .pin_b    (pin_b),
   .pin_b_oe (pin_b_oe)
);

// File: tb/tb_wtc_chan.sv
`timescale 1ns/100ps
module tb_wtc_chan;
   localparam int W = 4;

   typedef struct packed {
      logic [1:0] b_sw, b_ext, b_rc, b_cmp;
      logic [1:0] a_sw, a_ext, a_rc, a_cmp;
      logic [1:0] wave;
      logic       etrig;
      logic [1:0] esrc, eedge;
      logic       rdis, rstop;
      logic [1:0] gate;
      logic       inv;
      logic [1:0] csrc;
   } mw_t;

   // [6:5] sw action, [4:3] ext action, [2] fire sw, [1] fire ext, [0] expected pin A
   localparam logic [6:0] TBL [11] = '{
      7'b0100101, 7'b1000100, 7'b1100101, 7'b1100100, 7'b0001011, 7'b0011010,
      7'b0110111, 7'b1001110, 7'b0001111, 7'b1100011, 7'b1010001};

   logic clk = 1'b0, rst_n = 1'b0, tick_in = 1'b0, pin_b_in = 1'b0;
   logic [2:0] aux_in = '0;
   logic cfg_wr = 1'b0, wprot = 1'b0, cmd_en = 1'b0, cmd_dis = 1'b0, cmd_trig = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [29:0] cfg_wdata = '0;
   logic [W-1:0] cnt_val;
   logic pin_a, pin_b, pin_b_oe, hit_ra, hit_rb, hit_rc;
   logic s_ra, s_rb, s_rc;
   int total = 0, bad = 0;
   bit done = 1'b0;
   mw_t m;

   always #2.5 clk = ~clk;

   wtc_chan #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .aux_in(aux_in), .pin_b_in(pin_b_in),
      .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .wprot(wprot),
      .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_trig(cmd_trig), .cnt_val(cnt_val),
      .pin_a(pin_a), .pin_b(pin_b), .pin_b_oe(pin_b_oe),
      .hit_ra(hit_ra), .hit_rb(hit_rb), .hit_rc(hit_rc));

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] a, input logic [29:0] d);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cmd(input logic e, input logic d, input logic t);
      cmd_en = e; cmd_dis = d; cmd_trig = t;
      @(negedge clk);
      cmd_en = 1'b0; cmd_dis = 1'b0; cmd_trig = 1'b0;
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) begin
         tick_in = 1'b1;
         @(negedge clk);
         s_ra = hit_ra; s_rb = hit_rb; s_rc = hit_rc;
         tick_in = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic apulse(input int idx);
      aux_in[idx] = 1'b1;
      @(negedge clk);
      aux_in[idx] = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cnt", cnt_val, 0);
      chk("R1 pin_a", pin_a, 0);
      chk("R1 pin_b", pin_b, 0);
      chk("R1 pin_b_oe", pin_b_oe, 0);
      chk("R1 hits", {hit_ra, hit_rb, hit_rc}, 0);
      tick(2);
      chk("R3 disabled after reset", cnt_val, 0);

      // R10 R11 action table on pin A
      for (int i = 0; i < 11; i++) begin
         m = '0; m.esrc = 2'd1; m.eedge = 2'd1;
         m.a_sw = TBL[i][6:5]; m.a_ext = TBL[i][4:3];
         cfg(2'd0, m);
         cmd_trig = TBL[i][2]; aux_in[0] = TBL[i][1];
         @(negedge clk);
         cmd_trig = 1'b0; aux_in[0] = 1'b0;
         @(negedge clk);
         chk($sformatf("R10/R11 vec%0d", i), pin_a, TBL[i][0]);
      end

      // R2 write protect
      wprot = 1'b1;
      m = '0; cfg(2'd0, m);
      chk("R2 mode locked", pin_b_oe, 1);
      cfg(2'd3, 30'd9);
      wprot = 1'b0;

      // R4 R3 up counting and commands
      m = '0; m.esrc = 2'd1; cfg(2'd0, m);
      cmd(1'b1, 1'b0, 1'b0);
      cmd(1'b0, 1'b0, 1'b1);
      tick(3);
      chk("R4 count 3", cnt_val, 3);
      tick(12);
      chk("R4 count 15", cnt_val, 15);
      tick(1);
      chk("R4 wrap", cnt_val, 0);
      tick(2);
      cmd(1'b0, 1'b1, 1'b0);
      tick(1);
      chk("R3 dis holds", cnt_val, 2);
      cmd(1'b0, 1'b0, 1'b1);
      tick(1);
      chk("R3 trig when disabled", cnt_val, 0);
      cmd(1'b1, 1'b0, 1'b0);
      tick(1);
      chk("R3 enable alone", cnt_val, 0);
      cmd(1'b0, 1'b0, 1'b1);
      tick(1);
      chk("R3 restart", cnt_val, 1);

      // R5 invert and source select
      m.inv = 1'b1; cfg(2'd0, m);
      tick_in = 1'b1; @(negedge clk);
      chk("R5 no count on rise", cnt_val, 1);
      tick_in = 1'b0; @(negedge clk);
      chk("R5 count on fall", cnt_val, 2);
      m.inv = 1'b0; m.csrc = 2'd2; cfg(2'd0, m);
      tick(1);
      chk("R5 tick ignored", cnt_val, 2);
      apulse(1);
      chk("R5 aux1 source", cnt_val, 3);

      // R6 gating
      m.csrc = 2'd0; m.gate = 2'd3; cfg(2'd0, m);
      tick(1);
      chk("R6 gated off", cnt_val, 3);
      aux_in[2] = 1'b1; @(negedge clk);
      tick(1);
      chk("R6 gated on", cnt_val, 4);
      aux_in[2] = 1'b0; @(negedge clk);

      // R7 R14 auto reload
      cfg(2'd3, 30'd5);
      m.gate = 2'd0; m.wave = 2'd2; cfg(2'd0, m);
      cmd(1'b0, 1'b0, 1'b1);
      tick(5);
      chk("R7 at RC", cnt_val, 5);
      chk("R14 hit_rc pulse", s_rc, 1);
      chk("R14 hit_rc one cycle", hit_rc, 0);
      tick(1);
      chk("R7 reload", cnt_val, 0);

      // R8 up-down
      cfg(2'd3, 30'd3);
      m.wave = 2'd3; cfg(2'd0, m);
      cmd(1'b0, 1'b0, 1'b1);
      begin
         int exp_seq[7] = '{1, 2, 3, 2, 1, 0, 1};
         for (int k = 0; k < 7; k++) begin
            tick(1);
            chk($sformatf("R8 rc step%0d", k), cnt_val, exp_seq[k]);
         end
      end
      m.wave = 2'd1; cfg(2'd0, m);
      cmd(1'b0, 1'b0, 1'b1);
      tick(15);
      chk("R8 top", cnt_val, 15);
      tick(2);
      chk("R8 down from max", cnt_val, 13);

      // R9 halt and lock on RC
      cfg(2'd3, 30'd4);
      m.wave = 2'd0; m.rstop = 1'b1; cfg(2'd0, m);
      cmd(1'b0, 1'b0, 1'b1);
      tick(6);
      chk("R9 halt at RC", cnt_val, 4);
      cmd(1'b0, 1'b0, 1'b1);
      tick(1);
      chk("R9 trig restarts", cnt_val, 1);
      m.rstop = 1'b0; m.rdis = 1'b1; cfg(2'd0, m);
      cmd(1'b0, 1'b0, 1'b1);
      tick(6);
      chk("R9 lock at RC", cnt_val, 4);
      cmd(1'b0, 1'b0, 1'b1);
      tick(1);
      chk("R9 locked trig", cnt_val, 0);
      cmd(1'b1, 1'b0, 1'b0);
      cmd(1'b0, 1'b0, 1'b1);
      tick(1);
      chk("R9 enable then trig", cnt_val, 1);

      // R10 R14 compare actions
      cfg(2'd1, 30'd2); cfg(2'd2, 30'd4); cfg(2'd3, 30'd6);
      m = '0; m.esrc = 2'd1; m.wave = 2'd2;
      m.a_cmp = 2'd1; m.a_rc = 2'd2; m.a_sw = 2'd2;
      m.b_cmp = 2'd1; m.b_rc = 2'd2; m.b_sw = 2'd2;
      cfg(2'd0, m);
      cmd(1'b0, 1'b0, 1'b1);
      chk("R10 sw clear A", pin_a, 0);
      chk("R10 sw clear B", pin_b, 0);
      tick(2);
      chk("R10 RA sets A", pin_a, 1);
      chk("R14 hit_ra", s_ra, 1);
      tick(2);
      chk("R10 RB sets B", pin_b, 1);
      chk("R14 hit_rb", s_rb, 1);
      tick(2);
      chk("R10 RC clears A", pin_a, 0);
      chk("R10 RC clears B", pin_b, 0);
      chk("R14 hit_rc", s_rc, 1);

      // R12 external event
      m = '0; m.esrc = 2'd1; m.eedge = 2'd2; m.etrig = 1'b1; m.a_ext = 2'd3;
      cfg(2'd0, m);
      cmd(1'b0, 1'b0, 1'b1);
      tick(3);
      aux_in[0] = 1'b1; @(negedge clk);
      chk("R12 rise ignored cnt", cnt_val, 3);
      chk("R12 rise ignored pin", pin_a, 0);
      aux_in[0] = 1'b0; @(negedge clk);
      chk("R12 fall trig cnt", cnt_val, 0);
      chk("R12 fall toggles", pin_a, 1);
      m.etrig = 1'b0; m.eedge = 2'd3; cfg(2'd0, m);
      tick(2);
      aux_in[0] = 1'b1; @(negedge clk);
      chk("R12 both rise pin", pin_a, 0);
      aux_in[0] = 1'b0; @(negedge clk);
      chk("R12 both fall pin", pin_a, 1);
      chk("R12 no counter effect", cnt_val, 2);
      m.eedge = 2'd0; cfg(2'd0, m);
      apulse(0);
      chk("R12 edge none", pin_a, 1);

      // R13 pin B as event input
      m = '0; m.esrc = 2'd0; m.eedge = 2'd1; m.etrig = 1'b1; m.b_sw = 2'd3;
      cfg(2'd0, m);
      chk("R13 oe low", pin_b_oe, 0);
      cmd(1'b0, 1'b0, 1'b1);
      chk("R13 pin B frozen", pin_b, 0);
      tick(2);
      pin_b_in = 1'b1; @(negedge clk);
      chk("R13 pin B input triggers", cnt_val, 0);
      pin_b_in = 1'b0; @(negedge clk);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule